// File: doc/BRIEF.md
# Timer input capture unit

The block watches one synchronized input pin and, when a selected event happens on it, copies the value of a free-running 16-bit timer into a capture register. Two timer inputs arrive at the block, and a select bit chooses which of them is latched. A 4-bit mode field switches the unit off or picks one of four events. The events are every falling edge, every rising edge, every 4th rising edge and every 16th rising edge. Each capture raises a sticky interrupt flag. Software lowers the flag through an explicit clear input.

Each capture overwrites the previous value, whether or not software has read it. The rising-edge prescaler is cleared only while the unit is off or the mode field holds a non-capture code. Changing from one prescale ratio to another therefore keeps the partial count, and the first capture after the change can come early. The edge history is also kept while the unit is off, so a mode write can itself produce a capture. Software that wants a clean change first writes the off code and then writes the new mode.

Top module: `cap_unit`

## Requirements
- R1: After reset the capture value is 0, the flag is 0 and the prescaler count is 0. With mode 0110 set straight after reset, the 4th rising edge is the first one that captures.
- R2: With mode 0100, a falling edge captures. The edge is pin low in a cycle after pin high in the previous cycle. The timer value present in the edge cycle shows on cap_val_o after that clock edge. Rising edges do not capture in this mode.
- R3: With mode 0101, every rising edge captures, and falling edges do not.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. In these modes the count advances only on rising edges.
- R5: tmr_sel_i = 0 captures tmr_a_i, and tmr_sel_i = 1 captures tmr_b_i, using the select value of the edge cycle.
- R6: A capture sets flag_o. The flag stays set until a cycle with flag_clr_i = 1. If a capture and a clear fall in the same cycle, the capture wins and the flag stays set.
- R7: A new capture overwrites the previous value, with no lock and no overflow indication.
- R8: Any mode whose upper two bits are not 01 is a non-capture mode, and 0000 is off. A non-capture mode never captures and clears the prescaler count.
- R9: A direct change between 0110 and 0111 keeps the count. In a prescaled mode, a rising edge captures and resets the count to 0 when the count is at least the ratio minus one. Otherwise the edge adds one to the count.
- R10: The pin history is updated in every mode. An edge that arrives in the same cycle as a change from a non-capture mode to a matching capture mode captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode field: off, capture events, or non-capture codes |
| tmr_sel_i | input | 1 | Selects which timer input is captured |
| pin_i | input | 1 | Synchronized event pin |
| tmr_a_i | input | 16 | Timer input 0 |
| tmr_b_i | input | 16 | Timer input 1 |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| cap_val_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture flag |

## Verification
The edge decision and the capture happen at the clock edge that ends the cycle in which the pin first differs from its previous sample. The captured value and the flag are therefore due one clock after the inputs are applied. The bench drives inputs 1 ns after a rising edge, steps its model over those inputs, and compares cap_val_o and flag_o 1 ns after the next rising edge. A clear, a mode change and a prescaler advance take effect at that same edge, so every check samples exactly one clock after its stimulus.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_FALL = 2'd1,
    EV_RISE = 2'd2,
    EV_PRE  = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/cap_mode_dec.sv
module cap_mode_dec #(
  parameter int MW    = 4,
  parameter int R_LO  = 4,
  parameter int R_HI  = 16,
  parameter int PS_W  = $clog2(R_HI)
) (
  input  logic [MW-1:0]    mode_i,
  output logic             cap_en_o,
  output cap_pkg::ev_kind_e ev_o,
  output logic [PS_W-1:0]  ratio_m1_o
);
  import cap_pkg::*;

  localparam logic [PS_W-1:0] LO_M1 = PS_W'(R_LO - 1);
  localparam logic [PS_W-1:0] HI_M1 = PS_W'(R_HI - 1);

  always_comb begin
    cap_en_o   = (mode_i[3:2] == 2'b01);
    ev_o       = EV_NONE;
    ratio_m1_o = '0;
    if (cap_en_o) begin
      unique case (mode_i[1:0])
        2'b00: ev_o = EV_FALL;
        2'b01: ev_o = EV_RISE;
        2'b10: begin ev_o = EV_PRE; ratio_m1_o = LO_M1; end
        default: begin ev_o = EV_PRE; ratio_m1_o = HI_M1; end
      endcase
    end
  end
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  // history runs in every mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign rise_o = pin_i & ~prev_q;
  assign fall_o = ~pin_i & prev_q;

  // R2
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_en_i,
  input  logic            pre_en_i,
  input  logic            rise_i,
  input  logic [PS_W-1:0] ratio_m1_i,
  output logic            tick_o
);
  logic [PS_W-1:0] cnt_q;
  logic            wrap;

  // stale counts above the new limit wrap at once
  assign wrap   = (cnt_q >= ratio_m1_i);
  assign tick_o = pre_en_i & rise_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!cap_en_i)      cnt_q <= '0;
    else if (pre_en_i && rise_i)
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R8
  pre_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> (cnt_q == '0));

  // R4
  pre_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && pre_en_i && rise_i && (cnt_q < ratio_m1_i))
      |=> (cnt_q == PS_W'($past(cnt_q) + 1'b1)));

  // R9
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
  parameter int TW   = 16,
  parameter int MW   = 4,
  parameter int R_LO = 4,
  parameter int R_HI = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [MW-1:0] mode_i,
  input  logic          tmr_sel_i,
  input  logic          pin_i,
  input  logic [TW-1:0] tmr_a_i,
  input  logic [TW-1:0] tmr_b_i,
  input  logic          flag_clr_i,
  output logic [TW-1:0] cap_val_o,
  output logic          flag_o
);
  import cap_pkg::*;

  localparam int PS_W = $clog2(R_HI);

  logic            cap_en, rise, fall, tick, fire;
  ev_kind_e        ev;
  logic [PS_W-1:0] ratio_m1;
  logic [TW-1:0]   tmr_sel, cap_q;
  logic            flag_q;

  cap_mode_dec #(.MW(MW), .R_LO(R_LO), .R_HI(R_HI), .PS_W(PS_W)) u_dec (
    .mode_i    (mode_i),
    .cap_en_o  (cap_en),
    .ev_o      (ev),
    .ratio_m1_o(ratio_m1)
  );

  cap_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  cap_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .pre_en_i  (ev == EV_PRE),
    .rise_i    (rise),
    .ratio_m1_i(ratio_m1),
    .tick_o    (tick)
  );

  assign tmr_sel = tmr_sel_i ? tmr_b_i : tmr_a_i;

  always_comb begin
    unique case (ev)
      EV_FALL: fire = fall;
      EV_RISE: fire = rise;
      EV_PRE:  fire = tick;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (fire) cap_q <= tmr_sel;
  end

  // capture beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (fire)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cap_val_o = cap_q;
  assign flag_o    = flag_q;

  // R8
  no_cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en |-> !fire);

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> flag_o);

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R7
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (cap_val_o == $past(tmr_sel_i ? tmr_b_i : tmr_a_i)));

  // R7
  cap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(cap_val_o));
endmodule

// File: tb/cap_unit_bench.sv
module cap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        tsel = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] ta = 16'd0;
  logic [15:0] tb = 16'd0;
  logic        clr = 1'b0;
  logic [15:0] cap;
  logic        flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  logic        m_pp = 1'b0;
  int          m_cnt = 0;
  logic [15:0] m_cap = 16'd0;
  logic        m_flag = 1'b0;

  always #2 clk = ~clk;

  cap_unit u_cap_unit (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .tmr_sel_i (tsel),
    .pin_i     (pin),
    .tmr_a_i   (ta),
    .tmr_b_i   (tb),
    .flag_clr_i(clr),
    .cap_val_o (cap),
    .flag_o    (flag)
  );

  function automatic bit exp_fire(input logic [3:0] md, input logic p,
                                  input logic pp, input int cnt);
    bit r = p & ~pp;
    bit f = ~p & pp;
    case (md)
      4'b0100: return f;
      4'b0101: return r;
      4'b0110: return r && (cnt >= 3);
      4'b0111: return r && (cnt >= 15);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_cnt(input logic [3:0] md, input logic p,
                                 input logic pp, input int cnt);
    int lim;
    if (md[3:2] != 2'b01) return 0;
    if (md[1] == 1'b0 || !(p & ~pp)) return cnt;
    lim = md[0] ? 15 : 3;
    return (cnt >= lim) ? 0 : cnt + 1;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input string tag);
    bit fr = exp_fire(mode, pin, m_pp, m_cnt);
    m_cnt = exp_cnt(mode, pin, m_pp, m_cnt);
    if (fr) m_cap = tsel ? tb : ta;
    m_flag = fr ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_pp = pin;
    @(posedge clk);
    #1;
    chk({tag, " cap"}, int'(cap), int'(m_cap));
    chk({tag, " flag"}, int'(flag), int'(m_flag));
  endtask

  task automatic pulse(input string tag);
    pin = 1'b1; cyc(tag);
    pin = 1'b0; cyc(tag);
  endtask

  task automatic clear_flag();
    clr = 1'b1; cyc("R6 clear");
    clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7713));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset cap", int'(cap), 0);
    chk("R1 reset flag", int'(flag), 0);

    // R1/R4: count starts from zero after reset
    mode = 4'b0110;
    repeat (3) pulse("R1 pre");
    chk("R4 no capture before 4th", int'(flag), 0);
    ta = 16'h4444;
    pin = 1'b1; cyc("R4 4th edge");
    chk("R4 capture on 4th", int'(cap), 16'h4444);
    pin = 1'b0; cyc("R4");
    clear_flag();
    chk("R6 cleared", int'(flag), 0);

    // R2: falling edge only
    mode = 4'b0100; ta = 16'h1111;
    pin = 1'b1; cyc("R2 rise ignored");
    chk("R2 rise ignored", int'(flag), 0);
    ta = 16'hA5A5;
    pin = 1'b0; cyc("R2 fall");
    chk("R2 fall value", int'(cap), 16'hA5A5);
    clear_flag();

    // R3/R5: rising edge, timer b
    mode = 4'b0101; tsel = 1'b1; tb = 16'h5A5A; ta = 16'h0001;
    pin = 1'b1; cyc("R3 rise");
    chk("R5 timer b", int'(cap), 16'h5A5A);
    tb = 16'h9999;
    pin = 1'b0; cyc("R3 fall ignored");
    chk("R3 fall ignored", int'(cap), 16'h5A5A);

    // R7: overwrite with flag still set
    tb = 16'h0F0F;
    pin = 1'b1; cyc("R7 overwrite");
    chk("R7 overwrite", int'(cap), 16'h0F0F);

    // R6: capture beats clear
    pin = 1'b0; tsel = 1'b0; ta = 16'h2222; cyc("R6");
    clr = 1'b1; pin = 1'b1; cyc("R6 set wins");
    chk("R6 set wins", int'(flag), 1);
    chk("R5 timer a", int'(cap), 16'h2222);
    cyc("R6 clear");
    chk("R6 clear", int'(flag), 0);
    clr = 1'b0; pin = 1'b0; cyc("R6");

    // R8: off clears count; non-capture codes never capture
    mode = 4'b0111;
    repeat (5) pulse("R8 pre");
    mode = 4'b0000; cyc("R8 off");
    mode = 4'b0111;
    repeat (15) pulse("R8 recount");
    chk("R8 no early capture", int'(flag), 0);
    pulse("R8 16th");
    chk("R8 16th capture", int'(flag), 1);
    clear_flag();
    mode = 4'b1101;
    repeat (4) pulse("R8 non-capture");
    chk("R8 non-capture", int'(flag), 0);

    // R9: stale count after direct ratio change
    mode = 4'b0111;
    repeat (6) pulse("R9 pre");
    mode = 4'b0110; ta = 16'h6666;
    pin = 1'b1; cyc("R9 early");
    chk("R9 early capture", int'(flag), 1);
    chk("R9 early value", int'(cap), 16'h6666);
    pin = 1'b0; cyc("R9");
    clear_flag();

    // R10: edge on the mode-write cycle
    mode = 4'b0000; cyc("R10");
    mode = 4'b0101; pin = 1'b1; ta = 16'h7777; cyc("R10 switch edge");
    chk("R10 switch capture", int'(cap), 16'h7777);
    pin = 1'b0; cyc("R10");
    clear_flag();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      ta = 16'($urandom); tb = 16'($urandom);
      if ($urandom % 20 == 0) begin
        case ($urandom % 8)
          0: mode = 4'b0100;
          1: mode = 4'b0101;
          2: mode = 4'b0110;
          3: mode = 4'b0111;
          4: mode = 4'b0000;
          default: mode = 4'($urandom);
        endcase
      end
      if ($urandom % 3 == 0) pin = ~pin;
      if ($urandom % 10 == 0) tsel = ~tsel;
      clr = ($urandom % 10 == 0);
      cyc("R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule